// File: doc/BRIEF.md
# Most-Significant-Word Signed Multiply Unit

This execution unit computes the upper 32 bits of a signed 64-bit multiply. Three operations are supported: plain multiply, multiply with an added accumulator, and multiply subtracted from an accumulator. Any of the three may also round. The caller supplies the 32-bit instruction word, three operand values and the current N, Z, C, V flags together with a valid strobe. The unit decodes the fields, tests the condition and returns a destination index, a write enable and the result word.

The unit is a two-stage pipeline. Stage one registers the signed product and the decoded control. Stage two places the accumulator in the upper half, adds or subtracts, applies rounding and registers the result. A new instruction can enter every cycle. Results leave two cycles after entry and in the order they came in. All 64-bit arithmetic wraps modulo 2^64.

Top module: `msw_mac`

## Requirements
- R1: While rst_ni is low, and after it is released until a valid instruction has passed through, valid_o and we_o are low.
- R2: When the accumulator field instr_i[15:12] equals 15, result_o is bits 63:32 of the signed product rn_val_i*rm_val_i. ra_val_i and instr_i[6] have no effect in this case.
- R3: When instr_i[15:12] is not 15 and instr_i[6] is 0, the 64-bit value is (ra_val_i<<32) plus the product.
- R4: When instr_i[15:12] is not 15 and instr_i[6] is 1, the 64-bit value is (ra_val_i<<32) minus the product.
- R5: When instr_i[5] is 1, 0x80000000 is added to the 64-bit value before bits 63:32 are taken.
- R6: rd_idx_o carries instr_i[19:16] of the same instruction.
- R7: The condition code instr_i[31:28] is tested against flags_i = {N,Z,C,V}. The codes are 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, A N==V, B N!=V, C !Z&(N==V), D Z|(N!=V), and E is always true. we_o is high with valid_o exactly when the test passes.
- R8: Condition code 0xF never executes: valid_o is high and we_o is low.
- R9: valid_o rises exactly two cycles after each valid_i. Back-to-back inputs produce back-to-back results in the same order.
- R10: Additions and subtractions wrap modulo 2^64, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction present |
| instr_i | input | 32 | Instruction word |
| rn_val_i | input | 32 | First multiplicand |
| rm_val_i | input | 32 | Second multiplicand |
| ra_val_i | input | 32 | Accumulator word |
| flags_i | input | 4 | Condition flags {N,Z,C,V} |
| valid_o | output | 1 | Result slot present |
| we_o | output | 1 | Destination write enable |
| rd_idx_o | output | 4 | Destination register index |
| result_o | output | 32 | Upper result word |

## Verification
Subtraction and rounding can act in the same cycle. Their combined carry and borrow decide the upper word. The bench provokes this with a small product taken from a zero accumulator while rounding is on, so the borrow runs through all 64 bits and the rounding constant then carries the value back across bit 32. It also feeds a random mix in which both bits are set together. Every result is judged against a 64-bit model in the bench that applies the operation first and the rounding second.

// File: rtl/msw_pkg.sv
package msw_pkg;
  localparam int INSTR_W  = 32;
  localparam int IDX_W    = 4;
  localparam int CC_HI    = 31;
  localparam int RD_LO    = 16;
  localparam int RA_LO    = 12;
  localparam int SUB_BIT  = 6;
  localparam int RND_BIT  = 5;
  localparam logic [IDX_W-1:0] NO_ACC_IDX = 4'hF;

  typedef struct packed {
    logic             exec;
    logic             accum;
    logic             sub;
    logic             rnd;
    logic [IDX_W-1:0] rd;
  } msw_ctrl_t;

  // flags = {N,Z,C,V}
  function automatic logic cond_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    unique case (cc)
      4'h0: cond_pass = z;
      4'h1: cond_pass = !z;
      4'h2: cond_pass = c;
      4'h3: cond_pass = !c;
      4'h4: cond_pass = n;
      4'h5: cond_pass = !n;
      4'h6: cond_pass = v;
      4'h7: cond_pass = !v;
      4'h8: cond_pass = c && !z;
      4'h9: cond_pass = !c || z;
      4'hA: cond_pass = (n == v);
      4'hB: cond_pass = (n != v);
      4'hC: cond_pass = !z && (n == v);
      4'hD: cond_pass = z || (n != v);
      4'hE: cond_pass = 1'b1;
      default: cond_pass = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/msw_decode.sv
module msw_decode
  import msw_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [3:0]         flags_i,
  output msw_ctrl_t          ctrl_o
);
  logic [IDX_W-1:0] ra_idx;
  assign ra_idx = instr_i[RA_LO +: IDX_W];

  always_comb begin
    ctrl_o.exec  = cond_pass(instr_i[CC_HI -: 4], flags_i);
    ctrl_o.accum = (ra_idx != NO_ACC_IDX);
    ctrl_o.sub   = instr_i[SUB_BIT];
    ctrl_o.rnd   = instr_i[RND_BIT];
    ctrl_o.rd    = instr_i[RD_LO +: IDX_W];
  end
endmodule

// File: rtl/msw_mul_stage.sv
module msw_mul_stage
  import msw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  msw_ctrl_t         ctrl_i,
  input  logic [DATA_W-1:0] rn_i,
  input  logic [DATA_W-1:0] rm_i,
  input  logic [DATA_W-1:0] ra_i,
  output logic              valid_o,
  output msw_ctrl_t         ctrl_o,
  output logic [PROD_W-1:0] prod_o,
  output logic [DATA_W-1:0] acc_o
);
  logic [PROD_W-1:0] rn_ext, rm_ext, prod_d;
  assign rn_ext = {{DATA_W{rn_i[DATA_W-1]}}, rn_i};
  assign rm_ext = {{DATA_W{rm_i[DATA_W-1]}}, rm_i};
  assign prod_d = rn_ext * rm_ext; // low 2W bits of sign-extended product

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      prod_o <= '0;
      acc_o  <= '0;
    end else if (valid_i) begin
      ctrl_o <= ctrl_i;
      prod_o <= prod_d;
      acc_o  <= ra_i;
    end
  end

  p_stage1_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_rd_carried_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> ctrl_o.rd == $past(ctrl_i.rd));
endmodule

// File: rtl/msw_acc_stage.sv
module msw_acc_stage
  import msw_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  msw_ctrl_t         ctrl_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic              valid_o,
  output logic              we_o,
  output logic [IDX_W-1:0]  rd_o,
  output logic [DATA_W-1:0] result_o
);
  localparam logic [PROD_W-1:0] ROUND_K = PROD_W'(1) << (DATA_W - 1);

  logic [PROD_W-1:0] acc_sh, mixed, final_v;
  assign acc_sh = {acc_i, {DATA_W{1'b0}}};

  always_comb begin
    if (!ctrl_i.accum)   mixed = prod_i;
    else if (ctrl_i.sub) mixed = acc_sh - prod_i;
    else                 mixed = acc_sh + prod_i;
    final_v = ctrl_i.rnd ? mixed + ROUND_K : mixed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      we_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      we_o    <= valid_i && ctrl_i.exec;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_o     <= '0;
      result_o <= '0;
    end else if (valid_i) begin
      rd_o     <= ctrl_i.rd;
      result_o <= final_v[PROD_W-1:DATA_W];
    end
  end

  p_out_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_no_spurious_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_we_in_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> valid_o);
  p_plain_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ctrl_i.accum && !ctrl_i.rnd) |=> result_o == $past(prod_i[PROD_W-1:DATA_W]));
endmodule

// File: rtl/msw_mac.sv
module msw_mac
  import msw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [DATA_W-1:0] rn_val_i,
  input  logic [DATA_W-1:0] rm_val_i,
  input  logic [DATA_W-1:0] ra_val_i,
  input  logic [3:0]        flags_i,
  output logic              valid_o,
  output logic              we_o,
  output logic [3:0]        rd_idx_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int PROD_W = 2 * DATA_W;

  msw_ctrl_t         dec_ctrl, s1_ctrl;
  logic              s1_valid;
  logic [PROD_W-1:0] s1_prod;
  logic [DATA_W-1:0] s1_acc;

  msw_decode u_dec (
    .instr_i (instr_i),
    .flags_i (flags_i),
    .ctrl_o  (dec_ctrl)
  );

  msw_mul_stage #(.DATA_W(DATA_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .ctrl_i  (dec_ctrl),
    .rn_i    (rn_val_i),
    .rm_i    (rm_val_i),
    .ra_i    (ra_val_i),
    .valid_o (s1_valid),
    .ctrl_o  (s1_ctrl),
    .prod_o  (s1_prod),
    .acc_o   (s1_acc)
  );

  msw_acc_stage #(.DATA_W(DATA_W)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .ctrl_i   (s1_ctrl),
    .prod_i   (s1_prod),
    .acc_i    (s1_acc),
    .valid_o  (valid_o),
    .we_o     (we_o),
    .rd_o     (rd_idx_o),
    .result_o (result_o)
  );

  p_never_code_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:28] == 4'hF) |=> ##1 (valid_o && !we_o));
  p_always_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:28] == 4'hE) |=> ##1 we_o);
endmodule

// File: tb/msw_mac_bench.sv
module msw_mac_bench;
  logic        clk = 0, rst_ni = 0, valid_i = 0;
  logic [31:0] instr_i = 0, rn = 0, rm = 0, ra = 0;
  logic [3:0]  flags = 0;
  logic        valid_o, we_o;
  logic [3:0]  rd_idx_o;
  logic [31:0] result_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  msw_mac u_msw_mac (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .rn_val_i(rn), .rm_val_i(rm), .ra_val_i(ra), .flags_i(flags),
    .valid_o(valid_o), .we_o(we_o), .rd_idx_o(rd_idx_o), .result_o(result_o)
  );

  typedef struct { bit v; bit we; logic [3:0] rd; logic [31:0] res; string tag; } exp_t;
  exp_t pipe0, pipe1;

  function automatic logic [31:0] mk(logic [3:0] cc, logic [3:0] rd, logic [3:0] ra_f,
                                     bit sub, bit rnd, logic [3:0] rn_f);
    return {cc, 8'h75, rd, ra_f, 4'h3, 1'b0, sub, rnd, 1'b1, rn_f};
  endfunction

  function automatic bit ref_cond(logic [3:0] cc, logic [3:0] f);
    bit n = f[3], z = f[2], c = f[1], v = f[0];
    case (cc)
      0: return z;           1: return !z;
      2: return c;           3: return !c;
      4: return n;           5: return !n;
      6: return v;           7: return !v;
      8: return c & !z;      9: return !c | z;
      10: return n == v;     11: return n != v;
      12: return !z & (n == v); 13: return z | (n != v);
      14: return 1;          default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_res(logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c);
    longint p = longint'(signed'(a)) * longint'(signed'(b));
    logic [63:0] t = 64'(p);
    if (ins[15:12] != 4'hF) t = ins[6] ? ({c, 32'h0} - t) : ({c, 32'h0} + t);
    if (ins[5]) t = t + 64'h8000_0000;
    return t[63:32];
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // called at negedge: check slot from two inputs ago, then drive next
  task automatic step(bit v, logic [31:0] ins, logic [31:0] a, logic [31:0] b,
                      logic [31:0] c, logic [3:0] f, string tag);
    chk(valid_o == pipe1.v, "R9", "valid_o", 64'(valid_o), 64'(pipe1.v));
    if (pipe1.v) begin
      chk(we_o == pipe1.we, pipe1.we ? pipe1.tag : "R7", "we_o", 64'(we_o), 64'(pipe1.we));
      chk(rd_idx_o == pipe1.rd, "R6", "rd_idx_o", 64'(rd_idx_o), 64'(pipe1.rd));
      chk(result_o == pipe1.res, pipe1.tag, "result_o", 64'(result_o), 64'(pipe1.res));
    end
    pipe1 = pipe0;
    pipe0.v = v; pipe0.we = v && ref_cond(ins[31:28], f); pipe0.rd = ins[19:16];
    pipe0.res = ref_res(ins, a, b, c); pipe0.tag = tag;
    valid_i = v; instr_i = ins; rn = a; rm = b; ra = c; flags = f;
    @(negedge clk);
  endtask

  initial begin
    int unsigned seed = 32'd2024;
    void'($urandom(seed));
    pipe0 = '{0, 0, 0, 0, ""}; pipe1 = pipe0;
    repeat (3) @(negedge clk);
    chk(!valid_o && !we_o, "R1", "reset outputs", 64'({valid_o, we_o}), 64'(0));
    rst_ni = 1;
    @(negedge clk);
    chk(!valid_o && !we_o, "R1", "post-reset idle", 64'({valid_o, we_o}), 64'(0));
    // R2 most-negative squared, ra ignored, bit6 ignored
    step(1, mk(4'hE, 4'd1, 4'hF, 1, 0, 0), 32'h8000_0000, 32'h8000_0000, 32'hDEAD_BEEF, 0, "R2");
    step(1, mk(4'hE, 4'd2, 4'hF, 0, 0, 0), 32'hFFFF_FFFF, 32'h0000_0003, 32'h1234_5678, 0, "R2");
    // R3 accumulate with wrap R10
    step(1, mk(4'hE, 4'd3, 4'd4, 0, 0, 0), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, "R10");
    step(1, mk(4'hE, 4'd4, 4'd4, 0, 0, 0), 32'h0001_0000, 32'h0002_0000, 32'h0000_0010, 0, "R3");
    // R4 subtract and R5 rounding in same op
    step(1, mk(4'hE, 4'd5, 4'd0, 1, 1, 0), 32'h1, 32'h1, 32'h0, 0, "R5");
    step(1, mk(4'hE, 4'd6, 4'd0, 1, 0, 0), 32'h1, 32'h1, 32'h0, 0, "R4");
    step(1, mk(4'hE, 4'd7, 4'hF, 0, 1, 0), 32'h0000_8000, 32'h0001_0000, 32'h0, 0, "R5");
    // R7 condition failing and passing; R8 never
    step(1, mk(4'h0, 4'd8, 4'hF, 0, 0, 0), 32'h5, 32'h5, 0, 4'b0000, "R7");
    step(1, mk(4'h0, 4'd9, 4'hF, 0, 0, 0), 32'h5, 32'h5, 0, 4'b0100, "R7");
    step(1, mk(4'hF, 4'd10, 4'hF, 0, 0, 0), 32'h5, 32'h5, 0, 4'b1111, "R8");
    step(0, 0, 0, 0, 0, 0, "R9");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ins = $urandom();
      bit v = ($urandom() % 4) != 0;
      string tg = (ins[15:12] == 4'hF) ? "R2" : (ins[6] ? "R4" : "R3");
      if (ins[5]) tg = "R5";
      step(v, ins, $urandom(), $urandom(), $urandom(), 4'($urandom()), tg);
    end
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, "R9");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule